// File: doc/BRIEF.md
# Multi-Format Serial Audio Output Transmitter

This block turns parallel 24-bit stereo samples into a three-wire serial audio stream made of a bit clock, a word select and serial data. Samples come from one of four internal sources. Source 0 is the ADC path, source 1 is the digital input path, source 2 is the IEC 60958 receiver path and source 3 is the interpolator/mixer output. Each source comes with a valid flag. When the selected source is not valid, the block uses source 0.

A 3-bit format field selects the framing: I2S, MSB-justified, or LSB-justified at 16, 18, 20 or 24 bits. The two reserved codes behave as I2S. A mute control forces the data line to silence and leaves the clocks running. A power enable stops the whole output stage and holds every output low. The control inputs are plain levels driven by a separate register block. They are sampled at every frame start, so a change never splits a frame. While powered down, the block keeps no state that waits on the audio path, so raising the enable always restarts output.

The bit clock is derived from the block clock by a programmable divider. Each channel slot is 32 bit periods long, which gives 64 bit periods per stereo frame.

Top module: `audio_ser_tx`

## Requirements
- R1: While reset is asserted, or on every clock after a cycle with `pwr_en_i` low, `bclk_o`, `ws_o` and `sdata_o` are 0 and the bit position restarts at 0.
- R2: While powered, one bit period lasts 2*HALF_DIV clocks. `bclk_o` is low for the first HALF_DIV clocks of a bit period and high for the rest. A frame is 64 bit periods: `ws_o` is 0 for the 32 left-channel periods (positions 0..31) and 1 for the 32 right-channel periods (positions 32..63). `ws_o` and `sdata_o` change only at the start of a bit period.
- R3: With format code 000 (I2S), slot position 1 carries sample bit 23 and slot position 24 carries bit 0. Slot position 0 and positions 25..31 carry 0.
- R4: With format code 101 (MSB-justified), slot positions 0..23 carry sample bits 23..0. Positions 24..31 carry 0.
- R5: Format codes 001, 010, 011 and 100 select LSB-justified framing with W = 16, 18, 20 and 24 bits. Slot positions 32-W..31 carry the top W bits of the sample, MSB first, so bit 24-W of the sample is the last bit before the word-select edge. All earlier positions carry 0.
- R6: Format codes 110 and 111 produce exactly the I2S output of code 000.
- R7: `src_sel_i` value s (00..11) selects the sample pair at bits [24*s+23 : 24*s] of `src_left_i` and `src_right_i`, provided `src_vld_i[s]` is 1.
- R8: If `src_vld_i[src_sel_i]` is 0 at the frame start, the frame carries source 0.
- R9: When mute is captured as 1, `sdata_o` is 0 for the whole frame while `bclk_o` and `ws_o` run unchanged.
- R10: The first clock with `pwr_en_i` high starts bit position 0 of a left-channel slot.
- R11: Format, mute, source selection and both samples are captured on the clock that starts bit position 0. Later changes within the frame have no effect until the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| pwr_en_i | input | 1 | Output stage power enable (1 = running) |
| mute_i | input | 1 | Data mute (1 = silence) |
| fmt_i | input | 3 | Frame format code |
| src_sel_i | input | 2 | Source selector |
| src_vld_i | input | NSRC | Valid flag per source |
| src_left_i | input | NSRC*SW | Left samples of all sources, source s at [SW*s +: SW] |
| src_right_i | input | NSRC*SW | Right samples of all sources, source s at [SW*s +: SW] |
| bclk_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word select (0 = left, 1 = right) |
| sdata_o | output | 1 | Serial data |

## Verification
Two things can land on the same clock. One is the frame-start capture. The other is either a control change or the restart after power-up. The bench drives a new format, mute and source on the falling edge right before a frame-start edge, and also on the clock that power returns. The first bit of the new frame must then already follow the new settings. This matters most for MSB-justified framing, because position 0 carries data there. A behavioural model counts clocks since power-up and captures the controls only when that count is a multiple of the frame length. It compares all three outputs on every clock. Settings changed in the middle of a frame must leave the rest of that frame untouched.

// File: rtl/sat_pkg.sv
package sat_pkg;

  typedef enum logic [2:0] {
    FMT_I2S   = 3'b000,
    FMT_LSB16 = 3'b001,
    FMT_LSB18 = 3'b010,
    FMT_LSB20 = 3'b011,
    FMT_LSB24 = 3'b100,
    FMT_MSBJ  = 3'b101,
    FMT_RSV6  = 3'b110,
    FMT_RSV7  = 3'b111
  } fmt_e;

  // Word width of an LSB-justified format, 0 for every other code.
  function automatic int lsb_width(fmt_e f);
    case (f)
      FMT_LSB16: return 16;
      FMT_LSB18: return 18;
      FMT_LSB20: return 20;
      FMT_LSB24: return 24;
      default:   return 0;
    endcase
  endfunction

endpackage

// File: rtl/sat_clkgen.sv
module sat_clkgen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o,
  output logic bclk_o
);
  localparam int PERIOD = 2 * HALF_DIV;
  localparam int CNTW   = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CNTW-1:0] LAST  = CNTW'(PERIOD - 1);
  localparam logic [CNTW-1:0] HIGH  = CNTW'(HALF_DIV);
  localparam logic [CNTW-1:0] AFTER = CNTW'((HALF_DIV + 1) % PERIOD);

  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            bclk_q, bclk_d;

  assign tick_o = run_i && (cnt_q == '0);
  assign bclk_o = bclk_q;

  always_comb begin
    cnt_d  = cnt_q;
    bclk_d = bclk_q;
    if (!run_i) begin
      cnt_d  = '0;
      bclk_d = 1'b0;
    end else begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      if (cnt_q == '0)  bclk_d = 1'b0;
      if (cnt_q == HIGH) bclk_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      bclk_q <= bclk_d;
    end
  end

  // The bit clock only rises half a bit period into the slot.
  assert_bclk_mid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bclk_q) |-> (cnt_q == AFTER));

endmodule

// File: rtl/sat_framer.sv
module sat_framer #(
  parameter int SLOT = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          run_i,
  input  logic                          tick_i,
  output logic [$clog2(2*SLOT)-1:0]     pos_o,
  output logic                          frame_start_o
);
  localparam int POSW = $clog2(2 * SLOT);
  localparam logic [POSW-1:0] LAST = POSW'(2 * SLOT - 1);

  logic [POSW-1:0] pos_q, pos_d;

  assign pos_o         = pos_q;
  assign frame_start_o = tick_i && (pos_q == '0);

  always_comb begin
    pos_d = pos_q;
    if (!run_i)      pos_d = '0;
    else if (tick_i) pos_d = (pos_q == LAST) ? '0 : pos_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= '0;
    else         pos_q <= pos_d;
  end

  assert_frame_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && pos_q == LAST) |=> (pos_q == '0));

  assert_pos_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i) |=> $stable(pos_q) || !$past(run_i));

endmodule

// File: rtl/sat_srcsel.sv
module sat_srcsel #(
  parameter int NSRC = 4,
  parameter int SW   = 24
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [$clog2(NSRC)-1:0] sel_i,
  input  logic [NSRC-1:0]         vld_i,
  input  logic [NSRC*SW-1:0]      left_i,
  input  logic [NSRC*SW-1:0]      right_i,
  output logic [SW-1:0]           left_o,
  output logic [SW-1:0]           right_o
);
  localparam int SELW = $clog2(NSRC);

  logic [SW-1:0]   l_arr [NSRC];
  logic [SW-1:0]   r_arr [NSRC];
  logic [SELW-1:0] sel_eff;

  for (genvar g = 0; g < NSRC; g++) begin : g_unpack
    assign l_arr[g] = left_i[g*SW +: SW];
    assign r_arr[g] = right_i[g*SW +: SW];
  end

  // An invalid source falls back to source 0.
  assign sel_eff = vld_i[sel_i] ? sel_i : '0;
  assign left_o  = l_arr[sel_eff];
  assign right_o = r_arr[sel_eff];

  assert_fallback_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i[sel_i] |-> (left_o == left_i[SW-1:0] && right_o == right_i[SW-1:0]));

endmodule

// File: rtl/sat_serializer.sv
module sat_serializer
  import sat_pkg::*;
#(
  parameter int SW   = 24,
  parameter int SLOT = 32
) (
  input  fmt_e                      fmt_i,
  input  logic [SW-1:0]             smp_i,
  input  logic [$clog2(SLOT)-1:0]   slot_pos_i,
  output logic                      bit_o
);
  int            p;
  int            w;
  int            k;
  logic [SW-1:0] sh;

  always_comb begin
    p = int'(slot_pos_i);
    w = lsb_width(fmt_i);
    k = -1;
    if (w > 0) begin
      if (p >= SLOT - w) k = SW - 1 - (p - (SLOT - w));
    end else if (fmt_i == FMT_MSBJ) begin
      if (p < SW) k = SW - 1 - p;
    end else begin
      // I2S and the two reserved codes: one-bit delay after the slot edge.
      if (p >= 1 && p <= SW) k = SW - p;
    end
    sh    = (k >= 0) ? (smp_i >> k) : '0;
    bit_o = (k >= 0) && sh[0];
  end

endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx
  import sat_pkg::*;
#(
  parameter int NSRC     = 4,
  parameter int SW       = 24,
  parameter int SLOT     = 32,
  parameter int HALF_DIV = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    pwr_en_i,
  input  logic                    mute_i,
  input  logic [2:0]              fmt_i,
  input  logic [$clog2(NSRC)-1:0] src_sel_i,
  input  logic [NSRC-1:0]         src_vld_i,
  input  logic [NSRC*SW-1:0]      src_left_i,
  input  logic [NSRC*SW-1:0]      src_right_i,
  output logic                    bclk_o,
  output logic                    ws_o,
  output logic                    sdata_o
);
  localparam int POSW  = $clog2(2 * SLOT);
  localparam int SLOTW = $clog2(SLOT);

  logic            tick;
  logic            frame_start;
  logic [POSW-1:0] pos;
  logic [SW-1:0]   sel_l, sel_r;

  // Settings held for the running frame.
  fmt_e            fmt_q, fmt_d;
  logic            mute_q, mute_d;
  logic [SW-1:0]   l_q, l_d, r_q, r_d;
  logic            ws_q, ws_d, sd_q, sd_d;

  // Values that apply to the bit being launched.
  fmt_e            eff_fmt;
  logic            eff_mute;
  logic [SW-1:0]   eff_smp;
  logic            ser_bit;

  sat_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (pwr_en_i),
    .tick_o (tick),
    .bclk_o (bclk_o)
  );

  sat_framer #(.SLOT(SLOT)) u_framer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .run_i         (pwr_en_i),
    .tick_i        (tick),
    .pos_o         (pos),
    .frame_start_o (frame_start)
  );

  sat_srcsel #(.NSRC(NSRC), .SW(SW)) u_srcsel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (src_sel_i),
    .vld_i   (src_vld_i),
    .left_i  (src_left_i),
    .right_i (src_right_i),
    .left_o  (sel_l),
    .right_o (sel_r)
  );

  assign eff_fmt  = frame_start ? fmt_e'(fmt_i) : fmt_q;
  assign eff_mute = frame_start ? mute_i : mute_q;
  assign eff_smp  = pos[POSW-1] ? r_q : (frame_start ? sel_l : l_q);

  sat_serializer #(.SW(SW), .SLOT(SLOT)) u_ser (
    .fmt_i      (eff_fmt),
    .smp_i      (eff_smp),
    .slot_pos_i (pos[SLOTW-1:0]),
    .bit_o      (ser_bit)
  );

  always_comb begin
    fmt_d  = fmt_q;
    mute_d = mute_q;
    l_d    = l_q;
    r_d    = r_q;
    ws_d   = ws_q;
    sd_d   = sd_q;
    if (!pwr_en_i) begin
      ws_d = 1'b0;
      sd_d = 1'b0;
    end else if (tick) begin
      ws_d = pos[POSW-1];
      sd_d = !eff_mute && ser_bit;
      if (frame_start) begin
        fmt_d  = fmt_e'(fmt_i);
        mute_d = mute_i;
        l_d    = sel_l;
        r_d    = sel_r;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmt_q  <= FMT_I2S;
      mute_q <= 1'b0;
      l_q    <= '0;
      r_q    <= '0;
      ws_q   <= 1'b0;
      sd_q   <= 1'b0;
    end else begin
      fmt_q  <= fmt_d;
      mute_q <= mute_d;
      l_q    <= l_d;
      r_q    <= r_d;
      ws_q   <= ws_d;
      sd_q   <= sd_d;
    end
  end

  assign ws_o    = ws_q;
  assign sdata_o = sd_q;

  assert_pd_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_en_i |=> (!bclk_o && !ws_o && !sdata_o));

  assert_start_left_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_en_i && !$past(pwr_en_i)) |-> (frame_start && pos == '0));

  assert_mute_frame_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_en_i && mute_q && !frame_start && !$past(frame_start)) |-> !sdata_o);

  assert_ws_on_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_en_i && $past(pwr_en_i) && !$past(tick)) |-> $stable(ws_o) && $stable(sdata_o));

endmodule

// File: tb/tb_audio_ser_tx.sv
`timescale 1ns/1ps
module tb_audio_ser_tx;
  localparam int NSRC  = 4;
  localparam int SW    = 24;
  localparam int HALF  = 2;
  localparam int BITP  = 2 * HALF;
  localparam int FRAME = 64 * BITP;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               pwr_en;
  logic               mute;
  logic [2:0]         fmt;
  logic [1:0]         src_sel;
  logic [NSRC-1:0]    src_vld;
  logic [NSRC*SW-1:0] src_l, src_r;
  logic               bclk, ws, sd;

  always #4 clk = ~clk;

  audio_ser_tx #(.NSRC(NSRC), .SW(SW), .SLOT(32), .HALF_DIV(HALF)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_en_i(pwr_en), .mute_i(mute),
    .fmt_i(fmt), .src_sel_i(src_sel), .src_vld_i(src_vld),
    .src_left_i(src_l), .src_right_i(src_r),
    .bclk_o(bclk), .ws_o(ws), .sdata_o(sd));

  int n_cmp = 0;
  int n_bad = 0;
  int t = 0;
  bit done = 0;
  bit stirring = 1;

  // model state
  logic [2:0]  m_fmt;
  logic        m_mute;
  logic        m_fb;
  int          m_src;
  logic [23:0] m_l, m_r;
  logic        e_bclk, e_ws, e_sd;
  string       tag;

  function automatic logic ref_bit(input logic [2:0] f, input logic [23:0] s, input int p);
    int w;
    case (f)
      3'd1: w = 16;
      3'd2: w = 18;
      3'd3: w = 20;
      3'd4: w = 24;
      default: w = 0;
    endcase
    if (f == 3'd5) return (p < 24) ? s[23 - p] : 1'b0;
    if (w != 0)    return (p >= 32 - w) ? s[23 - (p - (32 - w))] : 1'b0;
    return (p >= 1 && p <= 24) ? s[24 - p] : 1'b0;
  endfunction

  always @(posedge clk) begin : model
    if (!rst_n || !pwr_en) begin
      t = 0; e_bclk = 0; e_ws = 0; e_sd = 0;
      tag = "R1";
    end else begin
      int p;
      p = (t / BITP) % 64;
      if (t % FRAME == 0) begin
        m_fb   = !src_vld[src_sel];
        m_src  = m_fb ? 0 : int'(src_sel);
        m_l    = src_l[m_src*SW +: SW];
        m_r    = src_r[m_src*SW +: SW];
        m_fmt  = fmt;
        m_mute = mute;
      end
      e_bclk = (t % BITP) >= HALF;
      if (t % BITP == 0) begin
        e_ws = (p >= 32);
        e_sd = m_mute ? 1'b0 : ref_bit(m_fmt, (p >= 32) ? m_r : m_l, p % 32);
      end
      if (t < FRAME)                                  tag = "R10";
      else if (fmt != m_fmt || mute != m_mute)        tag = "R11";
      else if (m_mute)                                tag = "R9";
      else if (m_fb)                                  tag = "R8";
      else if (m_src != 0)                            tag = "R7";
      else if (m_fmt >= 3'd6)                         tag = "R6";
      else if (m_fmt == 3'd5)                         tag = "R4";
      else if (m_fmt != 3'd0)                         tag = "R5";
      else                                            tag = "R3";
      t++;
    end
    #2;
    if (rst_n !== 1'b0 || !done) begin
      n_cmp++;
      if (bclk !== e_bclk) begin
        n_bad++;
        $display("FAIL %s bclk: actual %b expected %b (t=%0d)", (tag == "R1") ? "R1" : "R2", bclk, e_bclk, t);
      end
      if (ws !== e_ws) begin
        n_bad++;
        $display("FAIL %s ws: actual %b expected %b (t=%0d)", (tag == "R1") ? "R1" : "R2", ws, e_ws, t);
      end
      if (sd !== e_sd) begin
        n_bad++;
        $display("FAIL %s sdata: actual %b expected %b (t=%0d)", tag, sd, e_sd, t);
      end
    end
  end

  // Fresh sample data arrives at arbitrary times.
  always @(negedge clk) begin
    if (stirring && ($urandom % 37 == 0)) begin
      for (int i = 0; i < NSRC; i++) begin
        src_l[i*SW +: SW] = 24'($urandom);
        src_r[i*SW +: SW] = 24'($urandom);
      end
    end
  end

  // Waits for the falling edge just before a frame-start clock.
  task automatic before_frame();
    do @(negedge clk); while (t % FRAME != 0);
  endtask

  task automatic run_frames(input int n);
    repeat (n * FRAME) @(negedge clk);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    rst_n = 0; pwr_en = 0; mute = 0; fmt = 3'd0; src_sel = 2'd0; src_vld = '1;
    for (int i = 0; i < NSRC; i++) begin
      src_l[i*SW +: SW] = 24'hA5_0F_3C + 24'(i);
      src_r[i*SW +: SW] = 24'h5A_F0_C3 - 24'(i);
    end
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (6) @(negedge clk);              // R1: powered down, quiet
    pwr_en = 1;                             // R10: start at left slot
    run_frames(2);                          // R3: I2S
    for (int f = 1; f < 8; f++) begin       // R5, R4, R6
      before_frame();
      fmt = 3'(f);
      run_frames(2);
    end
    for (int s = 1; s < NSRC; s++) begin    // R7
      before_frame();
      fmt = 3'd5;
      src_sel = 2'(s);
      run_frames(1);
    end
    before_frame();                         // R8: invalid source
    src_vld = 4'b1011; src_sel = 2'd2; fmt = 3'd4;
    run_frames(2);
    src_vld = '1;
    before_frame();                         // R9 together with a format change
    mute = 1; fmt = 3'd1;
    run_frames(2);
    repeat (FRAME / 3) @(negedge clk);      // R11: mid-frame changes wait
    mute = 0; fmt = 3'd5; src_sel = 2'd3;
    run_frames(2);
    repeat (77) @(negedge clk);             // R1: power down mid-frame
    pwr_en = 0;
    repeat (40) @(negedge clk);
    fmt = 3'd2; src_sel = 2'd1;             // R10: restart with new settings
    pwr_en = 1;
    run_frames(2);
    stirring = 0;
    done = 1;
    @(negedge clk);
    report();
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
      $finish;
    end
  end

endmodule